// File: doc/BRIEF.md
# I2C Clock-Stretch Release Controller

This block keeps the I2C clock line held low once a byte and its acknowledge have been clocked. It counts falling SCL edges within a frame and starts the stretch on the falling edge that ends the acknowledge clock. Host register writes end the stretch. Each kind of write picks what the bus does next: send a new byte, keep receiving, issue a repeated START, or issue a STOP. The block turns the first valid action of a stretch into a one-cycle command pulse for the shifter and the bus sequencer, and drops the hold in the same cycle.

Two recovery paths act outside the normal release rules. Clearing the enable level drops the hold at once, and so does the bus-exit strobe. Both are meant for aborted transfers and deadlocked buses. While the wake-up mode flag is set, the four normal release actions have no effect.

Top module: `scl_hold_release`

## Requirements
- R1: The hold (`scl_hold`=1) starts on the FRAME_BITS-th (default 9th) falling SCL edge counted since the last `start_seen`, the last release or the last exit. `start_seen` clears the edge count.
- R2: A `wr_shift` strobe during a stretch drops the hold and pulses `resume_tx`.
- R3: A `wr_wrel` strobe during a stretch drops the hold and pulses `resume_rx`.
- R4: With `is_master`=1, a `wr_stt` strobe during a stretch pulses `restart_req` and a `wr_spt` strobe pulses `stop_req`. Both drop the hold.
- R5: With `is_master`=0, `wr_stt` and `wr_spt` produce no pulse and the hold stays at 1.
- R6: Only one release is taken per stretch. Strobes that arrive after the hold has dropped produce no pulse until the next stretch.
- R7: `wr_lrel` while enabled pulses `bus_exit`, drops the hold and clears the edge count.
- R8: A 1-to-0 change of `if_en` pulses `bus_exit` and drops the hold. While `if_en`=0, no edges are counted and no stretch begins.
- R9: While `wake_mode`=1, the strobes `wr_shift`, `wr_wrel`, `wr_stt` and `wr_spt` leave the stretch in place. Exit and disable still work.
- R10: When several strobes arrive in the same cycle, exactly one is taken, in this order: disable, bus exit, stop, start, data write, wait-release.
- R11: Every output pulse lasts one cycle. It appears in the cycle after the strobe is sampled, which is the cycle in which `scl_hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL line level |
| start_seen | input | 1 | START or repeated START detected on the bus (pulse) |
| is_master | input | 1 | Block currently owns the bus |
| if_en | input | 1 | Interface enable level |
| wake_mode | input | 1 | Wake-up mode flag; blocks normal release |
| wr_shift | input | 1 | Host wrote the transmit shift register |
| wr_wrel | input | 1 | Host set the wait-release bit |
| wr_stt | input | 1 | Host set the start-request bit |
| wr_spt | input | 1 | Host set the stop-request bit |
| wr_lrel | input | 1 | Host set the bus-exit bit |
| scl_hold | output | 1 | Drive SCL low |
| resume_tx | output | 1 | Pulse: shift out the newly written byte |
| resume_rx | output | 1 | Pulse: continue without new data |
| restart_req | output | 1 | Pulse: generate repeated START |
| stop_req | output | 1 | Pulse: generate STOP |
| bus_exit | output | 1 | Pulse: communication left, bus treated as idle |

## Verification
The bench sends a late shift-register write after a wait-release. A design that takes a second release would emit a stray `resume_tx` and corrupt SDA. It also fires all four release strobes in one cycle, and a wrong priority shows up as the wrong command pulse. Start and stop requests are also made while the block is not master: a design that honours them would end the stretch with no command to issue. Other sequences set wake-up mode, clear the enable level, and cut a frame short with START or bus exit. A design with a stale edge count would start the stretch on the wrong edge.

// File: rtl/sclr_pkg.sv
package sclr_pkg;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_DIS   = 3'd1,
    CZ_EXIT  = 3'd2,
    CZ_STOP  = 3'd3,
    CZ_START = 3'd4,
    CZ_DATA  = 3'd5,
    CZ_WREL  = 3'd6
  } cause_e;

  // Fixed-priority choice among candidate release causes.
  function automatic cause_e pick_cause(
    input logic dis, input logic ext, input logic stp,
    input logic sta, input logic dat, input logic wre);
    if (dis)      return CZ_DIS;
    else if (ext) return CZ_EXIT;
    else if (stp) return CZ_STOP;
    else if (sta) return CZ_START;
    else if (dat) return CZ_DATA;
    else if (wre) return CZ_WREL;
    else          return CZ_NONE;
  endfunction

  // Next edge count inside a frame, wrapping after the last bit.
  function automatic int unsigned next_count(input int unsigned cur, input int unsigned bits);
    return (cur == bits - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/sclr_frame_counter.sv
module sclr_frame_counter #(
  parameter int unsigned FRAME_BITS = 9,
  localparam int unsigned CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic enable,
  input  logic clear,
  input  logic holding,
  output logic scl_fall,
  output logic stretch_start
);
  logic          scl_q;
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign scl_fall      = scl_q & ~scl_in;
  assign at_last       = (int'(cnt_q) == int'(FRAME_BITS) - 1);
  assign stretch_start = enable & ~clear & ~holding & scl_fall & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      scl_q <= scl_in;
      if (!enable || clear)
        cnt_q <= '0;
      else if (scl_fall && !holding)
        cnt_q <= CW'(sclr_pkg::next_count(int'(cnt_q), FRAME_BITS));
    end
  end
endmodule

// File: rtl/sclr_release_arb.sv
module sclr_release_arb
  import sclr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   holding,
  input  logic   if_en,
  input  logic   wake_mode,
  input  logic   is_master,
  input  logic   wr_shift,
  input  logic   wr_wrel,
  input  logic   wr_stt,
  input  logic   wr_spt,
  input  logic   wr_lrel,
  output cause_e cause,
  output logic   exit_evt
);
  logic en_q;
  logic dis_evt;
  logic lrel_evt;
  logic rel_ok;

  assign dis_evt  = en_q & ~if_en;
  assign lrel_evt = if_en & wr_lrel;
  assign rel_ok   = if_en & holding & ~wake_mode;
  assign exit_evt = dis_evt | lrel_evt;

  assign cause = pick_cause(dis_evt, lrel_evt,
                            rel_ok & is_master & wr_spt,
                            rel_ok & is_master & wr_stt,
                            rel_ok & wr_shift,
                            rel_ok & wr_wrel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= if_en;
  end
endmodule

// File: rtl/sclr_hold_ctrl.sv
module sclr_hold_ctrl
  import sclr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   if_en,
  input  logic   stretch_start,
  input  cause_e cause,
  output logic   scl_hold,
  output logic   resume_tx,
  output logic   resume_rx,
  output logic   restart_req,
  output logic   stop_req,
  output logic   bus_exit
);
  logic hold_d;

  always_comb begin
    hold_d = scl_hold;
    if (!if_en || cause != CZ_NONE) hold_d = 1'b0;
    else if (stretch_start)         hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_hold    <= 1'b0;
      resume_tx   <= 1'b0;
      resume_rx   <= 1'b0;
      restart_req <= 1'b0;
      stop_req    <= 1'b0;
      bus_exit    <= 1'b0;
    end else begin
      scl_hold    <= hold_d;
      resume_tx   <= (cause == CZ_DATA);
      resume_rx   <= (cause == CZ_WREL);
      restart_req <= (cause == CZ_START);
      stop_req    <= (cause == CZ_STOP);
      bus_exit    <= (cause == CZ_DIS) || (cause == CZ_EXIT);
    end
  end
endmodule

// File: rtl/scl_hold_release.sv
module scl_hold_release #(
  parameter int unsigned FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic start_seen,
  input  logic is_master,
  input  logic if_en,
  input  logic wake_mode,
  input  logic wr_shift,
  input  logic wr_wrel,
  input  logic wr_stt,
  input  logic wr_spt,
  input  logic wr_lrel,
  output logic scl_hold,
  output logic resume_tx,
  output logic resume_rx,
  output logic restart_req,
  output logic stop_req,
  output logic bus_exit
);
  import sclr_pkg::*;

  // Named internal events, observed by the bound checker.
  logic   scl_fall;
  logic   stretch_start;
  logic   exit_evt;
  logic   release_any;
  cause_e cause;

  assign release_any = (cause != CZ_NONE);

  sclr_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .enable        (if_en),
    .clear         (start_seen | exit_evt | release_any),
    .holding       (scl_hold),
    .scl_fall      (scl_fall),
    .stretch_start (stretch_start)
  );

  sclr_release_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .holding   (scl_hold),
    .if_en     (if_en),
    .wake_mode (wake_mode),
    .is_master (is_master),
    .wr_shift  (wr_shift),
    .wr_wrel   (wr_wrel),
    .wr_stt    (wr_stt),
    .wr_spt    (wr_spt),
    .wr_lrel   (wr_lrel),
    .cause     (cause),
    .exit_evt  (exit_evt)
  );

  sclr_hold_ctrl u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .if_en         (if_en),
    .stretch_start (stretch_start),
    .cause         (cause),
    .scl_hold      (scl_hold),
    .resume_tx     (resume_tx),
    .resume_rx     (resume_rx),
    .restart_req   (restart_req),
    .stop_req      (stop_req),
    .bus_exit      (bus_exit)
  );
endmodule

// File: rtl/sclr_chk.sv
module sclr_chk (
  input logic clk,
  input logic rst_n,
  input logic if_en,
  input logic wake_mode,
  input logic is_master,
  input logic wr_shift,
  input logic wr_wrel,
  input logic wr_lrel,
  input logic stretch_start,
  input logic scl_hold,
  input logic resume_tx,
  input logic resume_rx,
  input logic restart_req,
  input logic stop_req,
  input logic bus_exit
);
  logic [4:0] pv;
  assign pv = {bus_exit, stop_req, restart_req, resume_rx, resume_tx};

  a_r1_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_start |=> scl_hold);

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pv));

  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 5'd0) |=> (pv == 5'd0));

  a_r6_cmd_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_tx | resume_rx | restart_req | stop_req) |-> (!scl_hold && $past(scl_hold)));

  a_r9_wake_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && wake_mode && if_en && !wr_lrel) |=> scl_hold);

  a_r5_slave_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !is_master && if_en && !wr_lrel && !wr_shift && !wr_wrel) |=> scl_hold);

  a_r8_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> !scl_hold);
endmodule

bind scl_hold_release sclr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .if_en         (if_en),
  .wake_mode     (wake_mode),
  .is_master     (is_master),
  .wr_shift      (wr_shift),
  .wr_wrel       (wr_wrel),
  .wr_lrel       (wr_lrel),
  .stretch_start (stretch_start),
  .scl_hold      (scl_hold),
  .resume_tx     (resume_tx),
  .resume_rx     (resume_rx),
  .restart_req   (restart_req),
  .stop_req      (stop_req),
  .bus_exit      (bus_exit)
);

// File: tb/sim_scl_hold_release.sv
module sim_scl_hold_release;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, start_seen = 1'b0, is_master = 1'b1, if_en = 1'b0, wake_mode = 1'b0;
  logic wr_shift = 1'b0, wr_wrel = 1'b0, wr_stt = 1'b0, wr_spt = 1'b0, wr_lrel = 1'b0;
  logic scl_hold, resume_tx, resume_rx, restart_req, stop_req, bus_exit;

  localparam logic [4:0] P_TX = 5'b00001, P_RX = 5'b00010, P_RS = 5'b00100,
                         P_SP = 5'b01000, P_EX = 5'b10000;

  typedef struct { logic [4:0] code; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  logic [4:0] prev_pv = 5'd0;

  always #2.5 clk = ~clk;

  scl_hold_release u0 (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every pulse seen must match the next queued item.
  always @(negedge clk) begin
    logic [4:0] pv;
    pv = {bus_exit, stop_req, restart_req, resume_rx, resume_tx};
    if (rst_n) begin
      if (pv != 5'd0) begin
        if (sb.size() == 0) check("R6 unexpected pulse", 32'(pv), 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, 32'(pv), 32'(e.code));
          check({e.req, " hold low with pulse (R11)"}, 32'(scl_hold), 32'd0);
        end
        if (prev_pv != 5'd0) check("R11 pulse longer than one cycle", 32'(prev_pv), 32'd0);
      end
      prev_pv = pv;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) begin
      scl_in = 1'b1; tick(); tick();
      scl_in = 1'b0; tick(); tick();
    end
    scl_in = 1'b1;
  endtask

  // One full frame; the hold must stay off until the last falling edge.
  task automatic frame();
    falls(8);
    check("R1 no hold before last edge", 32'(scl_hold), 32'd0);
    falls(1);
    check("R1 hold after last edge", 32'(scl_hold), 32'd1);
  endtask

  task automatic sync();
    start_seen = 1'b1; tick(); start_seen = 1'b0; tick();
  endtask

  task automatic strobe(input logic s, input logic w, input logic t, input logic p, input logic l);
    wr_shift = s; wr_wrel = w; wr_stt = t; wr_spt = p; wr_lrel = l;
    tick();
    wr_shift = 0; wr_wrel = 0; wr_stt = 0; wr_spt = 0; wr_lrel = 0;
    tick();
  endtask

  task automatic expect_pulse(input logic [4:0] c, input string r);
    exp_t e; e.code = c; e.req = r; sb.push_back(e);
  endtask

  initial begin
    tick(); tick();
    check("R1 reset hold", 32'(scl_hold), 32'd0);
    check("R11 reset pulses", 32'({bus_exit, stop_req, restart_req, resume_rx, resume_tx}), 32'd0);
    rst_n = 1'b1; if_en = 1'b1; tick(); tick();

    // R2 data write releases
    sync(); frame();
    expect_pulse(P_TX, "R2 data write"); strobe(1, 0, 0, 0, 0);
    check("R2 hold dropped", 32'(scl_hold), 32'd0);

    // R3 wait-release, then R6 late write ignored
    frame();
    expect_pulse(P_RX, "R3 wait release"); strobe(0, 1, 0, 0, 0);
    strobe(1, 0, 0, 0, 0);
    check("R6 late write hold", 32'(scl_hold), 32'd0);

    // R4 restart and stop as master
    frame();
    expect_pulse(P_RS, "R4 restart"); strobe(0, 0, 1, 0, 0);
    frame();
    expect_pulse(P_SP, "R4 stop"); strobe(0, 0, 0, 1, 0);

    // R5 non-master start/stop ignored
    is_master = 1'b0; frame();
    strobe(0, 0, 1, 0, 0); strobe(0, 0, 0, 1, 0);
    check("R5 hold kept", 32'(scl_hold), 32'd1);
    expect_pulse(P_RX, "R5 later wait release"); strobe(0, 1, 0, 0, 0);
    is_master = 1'b1;

    // R10 priority among same-cycle strobes
    frame(); expect_pulse(P_SP, "R10 stop wins"); strobe(1, 1, 1, 1, 0);
    frame(); expect_pulse(P_RS, "R10 start beats data"); strobe(1, 1, 1, 0, 0);
    frame(); expect_pulse(P_TX, "R10 data beats wrel"); strobe(1, 1, 0, 0, 0);
    frame(); expect_pulse(P_EX, "R10 exit beats stop"); strobe(0, 0, 0, 1, 1);

    // R9 wake mode blocks normal release, exit still works
    sync(); frame(); wake_mode = 1'b1;
    strobe(1, 0, 0, 0, 0); strobe(0, 1, 0, 0, 0); strobe(0, 0, 1, 1, 0);
    check("R9 hold kept in wake", 32'(scl_hold), 32'd1);
    expect_pulse(P_EX, "R9 exit in wake"); strobe(0, 0, 0, 0, 1);
    check("R9 exit drops hold", 32'(scl_hold), 32'd0);
    wake_mode = 1'b0;

    // R7 exit mid-frame clears the count
    falls(4); expect_pulse(P_EX, "R7 exit mid-frame"); strobe(0, 0, 0, 0, 1);
    frame(); expect_pulse(P_RX, "R7 release"); strobe(0, 1, 0, 0, 0);

    // R1 start_seen restarts the count
    falls(5); sync(); frame(); expect_pulse(P_TX, "R1 release"); strobe(1, 0, 0, 0, 0);

    // R8 disable drops hold, no counting while disabled
    frame();
    expect_pulse(P_EX, "R8 disable"); if_en = 1'b0; tick(); tick();
    check("R8 hold dropped", 32'(scl_hold), 32'd0);
    falls(9);
    check("R8 no stretch while off", 32'(scl_hold), 32'd0);
    if_en = 1'b1; tick(); sync(); frame();
    expect_pulse(P_RX, "R8 after re-enable"); strobe(0, 1, 0, 0, 0);

    tick(); tick();
    check("R6 scoreboard drained", 32'(sb.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule